// File: doc/BRIEF.md
# Byte-Stuffing Packet Framer

The framer takes a packet as a stream of bytes, one byte per valid/ready handshake, with flags marking the first and the last byte. It produces a physical byte stream for a serial link, also with a valid/ready handshake. Each frame opens with a start marker, a channel marker and the channel number zero. The payload follows. Reserved byte values are replaced by an escape code followed by the byte with bit 5 inverted. The end marker comes just before the final payload byte, not after it.

In wide mode the frame length is rounded up to a multiple of the link word size (parameter `WORD_BYTES`, default 4). Idle bytes are inserted directly ahead of the end marker to do this, so a word-oriented shifter downstream always receives whole words. The mode comes from a static configuration input. The framer reads it only when it accepts the first byte of a packet.

Top module: `stuff_framer`

## Requirements
- R1: Every frame starts with the three bytes 0x7A (start), 0x7C (channel), 0x00 (channel number), in that order.
- R2: A payload byte equal to 0x7A, 0x7B, 0x7C or 0x7D is sent as two bytes: 0x7D, then the byte XOR 0x20.
- R3: A payload byte equal to 0x4A or 0x4D is sent as two bytes: 0x4D, then the byte XOR 0x20.
- R4: The end marker 0x7B is sent immediately before the last payload byte. That last byte is escaped by the rules of R2 and R3 when it is reserved.
- R5: With `wordWide`=1, idle bytes 0x4A go directly before the end marker. Their count is the smallest that makes the frame length a multiple of `WORD_BYTES`.
- R6: With `wordWide`=0, no idle bytes are inserted. The end marker follows the escaped body directly.
- R7: `wordWide` is sampled when the first byte is accepted. Changing it later in the packet has no effect on that frame.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged. Backpressure never drops or repeats a byte.
- R9: A one-byte packet produces the header, any idles, then 0x7B, then that byte, escaped if it is reserved.
- R10: `inReady` and `outValid` are never high in the same cycle. One payload byte is held at a time.
- R11: After reset, `outValid` is 0 and `inReady` is 1.
- R12: A byte offered while no packet is open, and without the first flag, is consumed and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordWide | input | 1 | 1 = pad frames to `WORD_BYTES`, 0 = no padding |
| inValid | input | 1 | Payload byte offered |
| inReady | output | 1 | Payload byte accepted this cycle when valid |
| inData | input | 8 | Payload byte |
| inFirst | input | 1 | Byte is the first of a packet |
| inLast | input | 1 | Byte is the last of a packet |
| outValid | output | 1 | Link byte offered |
| outReady | input | 1 | Downstream takes the link byte |
| outData | output | 8 | Link byte |

## Verification
The assertions assume well-formed packets. The first flag is set only on the first byte and the last flag only on the last. The first flag never arrives on a byte inside an open packet. The bench sends only such packets, apart from deliberate stray bytes between packets. It also holds `inValid` and the byte steady until it sees the byte accepted. `outReady` is driven freely, both constantly high and from a pseudo-random pattern. Each link byte is compared with a behavioural model built from the payload queue and the mode that was sampled.

// File: rtl/stuff_framer_pkg.sv
package stuff_framer_pkg;
  localparam logic [7:0] MK_START = 8'h7A;
  localparam logic [7:0] MK_END   = 8'h7B;
  localparam logic [7:0] MK_CHAN  = 8'h7C;
  localparam logic [7:0] ESC_PKT  = 8'h7D;
  localparam logic [7:0] MK_IDLE  = 8'h4A;
  localparam logic [7:0] ESC_PHY  = 8'h4D;
  localparam logic [7:0] FLIP_BIT = 8'h20;

  typedef enum logic [2:0] {
    SEL_START, SEL_CHAN, SEL_ZERO, SEL_IDLE, SEL_END, SEL_ESC, SEL_DATA
  } selT;

  typedef struct packed {
    logic load;
    logic first;
    logic cntInc;
    logic pktDone;
    selT  sel;
  } ctrlT;

  function automatic logic isPktRes(input logic [7:0] b);
    return (b == MK_START) || (b == MK_END) || (b == MK_CHAN) || (b == ESC_PKT);
  endfunction

  function automatic logic isPhyRes(input logic [7:0] b);
    return (b == MK_IDLE) || (b == ESC_PHY);
  endfunction
endpackage

// File: rtl/stuff_framer_dp.sv
module stuff_framer_dp
  import stuff_framer_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlT       ctrl,
  input  logic [7:0] inData,
  input  logic       inLast,
  input  logic       wordWide,
  output logic [7:0] outData,
  output logic       heldLast,
  output logic       heldEsc,
  output logic       padPending
);
  localparam int CNT_W = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1;

  logic [7:0]       heldByte;
  logic             wideQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sumLen;
  logic             resPkt;
  logic             resPhy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldByte <= '0;
      heldLast <= 1'b0;
      wideQ    <= 1'b0;
      cnt      <= '0;
    end else begin
      if (ctrl.load) begin
        heldByte <= inData;
        heldLast <= inLast;
      end
      if (ctrl.first) begin
        wideQ <= wordWide;
        cnt   <= '0;
      end else if (ctrl.cntInc) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign resPkt  = isPktRes(heldByte);
  assign resPhy  = isPhyRes(heldByte);
  assign heldEsc = resPkt | resPhy;

  // bytes already sent + end marker + encoded last byte, modulo the word size
  assign sumLen     = cnt + CNT_W'(1) + (heldEsc ? CNT_W'(2) : CNT_W'(1));
  assign padPending = wideQ && (sumLen != '0);

  always_comb begin
    case (ctrl.sel)
      SEL_START: outData = MK_START;
      SEL_CHAN:  outData = MK_CHAN;
      SEL_ZERO:  outData = 8'h00;
      SEL_IDLE:  outData = MK_IDLE;
      SEL_END:   outData = MK_END;
      SEL_ESC:   outData = resPkt ? ESC_PKT : ESC_PHY;
      SEL_DATA:  outData = heldEsc ? (heldByte ^ FLIP_BIT) : heldByte;
      default:   outData = 8'h00;
    endcase
  end

  // R5: the last byte of a wide frame closes a whole word
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntInc && ctrl.pktDone && wideQ) |-> (cnt == CNT_W'(WORD_BYTES - 1)));

  // R2, R3: a data byte on the link is never a reserved value
  a_r2_no_raw_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntInc && ctrl.sel == SEL_DATA) |-> !(isPktRes(outData) || isPhyRes(outData)));

  // R6: narrow frames carry no idle bytes
  a_r6_no_pad_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cntInc && !wideQ) |-> (ctrl.sel != SEL_IDLE));
endmodule

// File: rtl/stuff_framer_ctrl.sv
module stuff_framer_ctrl
  import stuff_framer_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic inFirst,
  input  logic outReady,
  input  logic heldLast,
  input  logic heldEsc,
  input  logic padPending,
  output ctrlT ctrl,
  output logic inReady,
  output logic outValid
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CHAN, S_ZERO, S_DEC, S_FETCH, S_PAD, S_END, S_ESC, S_DATA
  } stT;

  stT st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    ctrl     = '0;
    ctrl.sel = SEL_ZERO;
    inReady  = 1'b0;
    outValid = 1'b0;
    nxt      = st;
    case (st)
      S_IDLE: begin
        inReady    = 1'b1;
        ctrl.load  = inValid && inFirst;
        ctrl.first = inValid && inFirst;
        if (inValid && inFirst) nxt = S_START;
      end
      S_START: begin
        outValid = 1'b1; ctrl.sel = SEL_START;
        if (outReady) nxt = S_CHAN;
      end
      S_CHAN: begin
        outValid = 1'b1; ctrl.sel = SEL_CHAN;
        if (outReady) nxt = S_ZERO;
      end
      S_ZERO: begin
        outValid = 1'b1; ctrl.sel = SEL_ZERO;
        if (outReady) nxt = S_DEC;
      end
      S_DEC: begin
        if (heldLast) nxt = padPending ? S_PAD : S_END;
        else          nxt = heldEsc ? S_ESC : S_DATA;
      end
      S_FETCH: begin
        inReady   = 1'b1;
        ctrl.load = inValid;
        if (inValid) nxt = S_DEC;
      end
      S_PAD: begin
        outValid = 1'b1; ctrl.sel = SEL_IDLE;
        if (outReady) nxt = S_DEC;
      end
      S_END: begin
        outValid = 1'b1; ctrl.sel = SEL_END;
        if (outReady) nxt = heldEsc ? S_ESC : S_DATA;
      end
      S_ESC: begin
        outValid = 1'b1; ctrl.sel = SEL_ESC;
        if (outReady) nxt = S_DATA;
      end
      S_DATA: begin
        outValid     = 1'b1; ctrl.sel = SEL_DATA;
        ctrl.pktDone = heldLast;
        if (outReady) nxt = heldLast ? S_IDLE : S_FETCH;
      end
      default: nxt = S_IDLE;
    endcase
    ctrl.cntInc = outValid && outReady;
  end

  // R10: input and output sides never active together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // R4: after the end marker leaves, the last held byte is what follows
  a_r4_end_then_last: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_END && outReady) |=> (heldLast && (st == S_ESC || st == S_DATA)));
endmodule

// File: rtl/stuff_framer.sv
module stuff_framer
  import stuff_framer_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordWide,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  input  logic       inFirst,
  input  logic       inLast,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData
);
  ctrlT ctrlS;
  logic heldLast, heldEsc, padPending;

  stuff_framer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .outReady(outReady), .heldLast(heldLast), .heldEsc(heldEsc),
    .padPending(padPending), .ctrl(ctrlS), .inReady(inReady), .outValid(outValid)
  );

  stuff_framer_dp #(.WORD_BYTES(WORD_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlS), .inData(inData), .inLast(inLast),
    .wordWide(wordWide), .outData(outData), .heldLast(heldLast),
    .heldEsc(heldEsc), .padPending(padPending)
  );

  // R8: a stalled byte is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R1: channel marker follows the start marker
  a_r1_chan_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && ctrlS.sel == SEL_START) |=> (outValid && outData == MK_CHAN));
endmodule

// File: tb/stuff_framer_tb.sv
module stuff_framer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wordWide = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = 8'h00;
  logic       inFirst = 1'b0;
  logic       inLast = 1'b0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  int rdyMode = 0;
  logic [15:0] rdyLfsr = 16'hACE1;
  logic [15:0] genLfsr = 16'h1D2B;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] pay[$];

  bit         prevStall = 0;
  logic [7:0] prevData = 8'h00;

  stuff_framer u_dut (
    .clk(clk), .rstN(rstN), .wordWide(wordWide), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inFirst(inFirst), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #5 clk = ~clk;

  function automatic bit resA(input logic [7:0] b);
    return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D;
  endfunction
  function automatic bit resB(input logic [7:0] b);
    return b == 8'h4A || b == 8'h4D;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string t);
    expQ.push_back(b);
    tagQ.push_back(t);
  endtask

  task automatic pushEnc(input logic [7:0] b, input string plainTag);
    if (resA(b)) begin push(8'h7D, "R2"); push(b ^ 8'h20, "R2"); end
    else if (resB(b)) begin push(8'h4D, "R3"); push(b ^ 8'h20, "R3"); end
    else push(b, plainTag);
  endtask

  // behavioural frame model
  task automatic expectPkt(input bit wide, input string hTag, input string mTag);
    int n;
    int ll;
    logic [7:0] lastB;
    int startSz;
    push(8'h7A, hTag); push(8'h7C, hTag); push(8'h00, hTag);
    startSz = expQ.size();
    for (int i = 0; i < pay.size() - 1; i++) pushEnc(pay[i], "R8");
    n = 3 + expQ.size() - startSz;
    lastB = pay[pay.size() - 1];
    ll = (resA(lastB) || resB(lastB)) ? 2 : 1;
    if (wide) begin
      int pads;
      pads = (4 - ((n + 1 + ll) % 4)) % 4;
      for (int i = 0; i < pads; i++) push(8'h4A, (mTag != "") ? mTag : "R5");
    end
    push(8'h7B, (mTag != "") ? mTag : (wide ? "R4" : "R6"));
    pushEnc(lastB, "R4");
  endtask

  task automatic sendByte(input logic [7:0] b, input logic f, input logic l);
    @(negedge clk);
    inValid = 1'b1; inData = b; inFirst = f; inLast = l;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendPkt(input bit wide, input bit flip, input string hTag, input string mTag);
    expectPkt(wide, hTag, mTag);
    wordWide = wide;
    for (int i = 0; i < pay.size(); i++) begin
      sendByte(pay[i], i == 0, i == pay.size() - 1);
      if (i == 0 && flip) wordWide = ~wide;
    end
    wait (expQ.size() == 0);
    wordWide = wide;
    pay.delete();
  endtask

  // monitor: output ready, reference comparison, hold and exclusivity checks
  always @(negedge clk) begin
    rdyLfsr = {rdyLfsr[14:0], rdyLfsr[15] ^ rdyLfsr[13] ^ rdyLfsr[12] ^ rdyLfsr[10]};
    outReady = (rdyMode == 0) ? 1'b1 : (rdyLfsr[0] & (rdyLfsr[1] | rdyLfsr[2]));
    #1;
    if (rstN) begin
      check(!(inReady && outValid), "R10", {6'b0, inReady, outValid}, 8'h00);
      if (prevStall) check(outValid && outData == prevData, "R8", outData, prevData);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12", outData, 8'h00);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outData == e, t, outData, e);
        end
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R11: reset state
    check(outValid == 1'b0, "R11", {7'b0, outValid}, 8'h00);
    check(inReady == 1'b1, "R11", {7'b0, inReady}, 8'h01);
    rstN = 1'b1;
    @(negedge clk); #2;
    check(outValid == 1'b0 && inReady == 1'b1, "R11", {6'b0, inReady, outValid}, 8'h02);

    // R12: stray byte outside a packet
    sendByte(8'h7A, 1'b0, 1'b0);
    repeat (4) begin
      @(negedge clk); #2;
      check(outValid == 1'b0, "R12", {7'b0, outValid}, 8'h00);
    end

    // R6: narrow frame, no escapes
    pay = '{8'h11, 8'h22, 8'h33};
    sendPkt(1'b0, 1'b0, "R1", "");
    // R5: wide frame, one idle expected
    pay = '{8'h11, 8'h22, 8'h33};
    sendPkt(1'b1, 1'b0, "R1", "");
    // R9: single byte, wide, three idles
    pay = '{8'h55};
    sendPkt(1'b1, 1'b0, "R9", "");
    // R9: single reserved byte, narrow
    pay = '{8'h7B};
    sendPkt(1'b0, 1'b0, "R9", "");
    // R2, R3: all reserved values, wide
    pay = '{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D, 8'h00, 8'h4A};
    sendPkt(1'b1, 1'b0, "R1", "");
    // R7: mode flipped after first byte
    pay = '{8'h01, 8'h7D, 8'h02};
    sendPkt(1'b1, 1'b1, "R1", "R7");
    pay = '{8'h03, 8'h4D, 8'h04, 8'h05};
    sendPkt(1'b0, 1'b1, "R1", "R7");

    // R8: backpressure with pseudo-random packets
    rdyMode = 1;
    for (int p = 0; p < 40; p++) begin
      int len;
      bit wide;
      genLfsr = {genLfsr[14:0], genLfsr[15] ^ genLfsr[13] ^ genLfsr[12] ^ genLfsr[10]};
      len = 1 + (genLfsr % 7);
      wide = genLfsr[5];
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        genLfsr = {genLfsr[14:0], genLfsr[15] ^ genLfsr[13] ^ genLfsr[12] ^ genLfsr[10]};
        case (genLfsr[2:0])
          3'd0: b = 8'h7A;
          3'd1: b = 8'h7D;
          3'd2: b = 8'h4A;
          3'd3: b = 8'h4D;
          default: b = genLfsr[15:8];
        endcase
        pay.push_back(b);
      end
      sendPkt(wide, genLfsr[9], (len == 1) ? "R9" : "R1", "");
    end

    repeat (5) @(negedge clk);
    #2;
    check(expQ.size() == 0 && outValid == 1'b0, "R8", {7'b0, outValid}, 8'h00);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule